// File: doc/BRIEF.md
# Four-Bank Synchronous RAM with Bank-Select Decoding

This block is a 4096-word by 8-bit random-access memory. Inside it are four banks of 1024 words each. The low ten address bits reach every bank as a word offset. The two high bits feed a 2-to-4 decoder, and each decoder output acts as the chip select of one bank. The banks therefore tile the address space as four adjacent 1K windows. The lowest window starts at word 0, and the top window ends at word 4095.

A single direction line chooses the operation in every clock cycle: 0 stores, 1 fetches. A store lands on the rising clock edge and reaches only the selected bank. A fetch is registered inside the selected bank, and the output multiplexer picks that bank using a bank index captured in the same cycle. The word therefore appears on the read port one cycle after its address. During store cycles the read port keeps showing the last fetched word.

Top module: `banked_ram`

## Requirements
- R1: Address bits [11:10] choose the bank and bits [9:0] the word inside it. Bank k serves addresses k*1024 through k*1024+1023, so a store on either side of a window boundary lands in a different bank.
- R2: With `rw` = 0, `wdata` is stored at `addr` on the rising clock edge. No other address changes, in the selected bank or any other bank.
- R3: With `rw` = 1, the word at `addr` appears on `rdata` after the next rising edge and stays there until at least the edge after it.
- R4: `rdata` comes from the bank chosen by the address of the previous cycle, including back-to-back fetches from different banks.
- R5: After a store cycle, `rdata` still shows the word from the most recent fetch, or 0 if none has happened since reset.
- R6: While `rst_n` is low, `rdata` is 0.
- R7: A fetch issued in the cycle right after a store to the same address returns the newly stored word.
- R8: In a store cycle exactly one bank is write-enabled. In a fetch cycle none is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the read path |
| addr | input | 12 | Word address; [11:10] bank, [9:0] offset |
| wdata | input | 8 | Word to store |
| rw | input | 1 | Direction: 0 store, 1 fetch |
| rdata | output | 8 | Registered read word |

## Verification
The assertions assume that `addr` and `rw` carry known values in every cycle after reset, and that only one operation is issued per cycle. The hold and single-writer properties depend on that. The stimulus changes inputs only on the falling clock edge, issues exactly one operation per cycle, and never fetches a word that it has not stored first. This keeps uninitialised array contents out of every comparison. Store cycles are interleaved between fetches so that the hold behaviour is exercised under the same conditions the assertions expect.

// File: rtl/banked_ram_pkg.sv
package banked_ram_pkg;

    localparam int unsigned DEF_ADDR_W = 12;
    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_SEL_W  = 2;

    typedef enum logic {
        OP_STORE = 1'b0,
        OP_FETCH = 1'b1
    } rw_op_e;

endpackage

// File: rtl/bank_decoder.sv
module bank_decoder #(
    parameter int unsigned SEL_W = 2,
    localparam int unsigned N_BANK = 1 << SEL_W
) (
    input  logic [SEL_W-1:0]  sel,
    output logic [N_BANK-1:0] cs
);

    for (genvar k = 0; k < N_BANK; k++) begin : g_line
        assign cs[k] = (sel == SEL_W'(k));
    end

    always_comb begin
        a_r1_one_select : assert ($onehot(cs) || $isunknown(sel));
    end

endmodule

// File: rtl/mem_bank.sv
module mem_bank
    import banked_ram_pkg::*;
#(
    parameter int unsigned OFF_W  = 10,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned DEPTH = 1 << OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rw,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] rd;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [DATA_W-1:0] cell_q [DEPTH];
    logic store_en, fetch_en;

    assign store_en = cs && (rw_op_e'(rw) == OP_STORE);
    assign fetch_en = cs && (rw_op_e'(rw) == OP_FETCH);

    always_comb begin
        st_d = st_q;
        if (fetch_en) begin
            st_d.rd = cell_q[off];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (store_en) begin
            cell_q[off] <= wdata;
        end
    end

    assign rdata = st_q.rd;

    // R2: an unselected bank keeps its registered word
    a_r2_idle_bank_hold : assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> $stable(rdata));

endmodule

// File: rtl/read_steer.sv
module read_steer
    import banked_ram_pkg::*;
#(
    parameter int unsigned SEL_W  = 2,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned N_BANK = 1 << SEL_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rw,
    input  logic [SEL_W-1:0]               sel,
    input  logic [N_BANK-1:0][DATA_W-1:0]  bank_rd,
    output logic [DATA_W-1:0]              rdata
);

    typedef struct packed {
        logic [SEL_W-1:0] src;
    } steer_state_t;

    steer_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rw_op_e'(rw) == OP_FETCH) begin
            st_d.src = sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = bank_rd[st_q.src];

    // R5: a store cycle leaves the read port untouched
    a_r5_store_holds_read : assert property (@(posedge clk) disable iff (!rst_n)
        (rw_op_e'(rw) == OP_STORE) |=> $stable(rdata));

    // R6: reset value of the port
    a_r6_reset_zero : assert property (@(posedge clk)
        $past(!rst_n) |-> (rdata == '0));

endmodule

// File: rtl/banked_ram.sv
module banked_ram
    import banked_ram_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned SEL_W  = DEF_SEL_W,
    localparam int unsigned OFF_W  = ADDR_W - SEL_W,
    localparam int unsigned N_BANK = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rw,
    output logic [DATA_W-1:0] rdata
);

    logic [SEL_W-1:0]               bank_sel;
    logic [OFF_W-1:0]               word_off;
    logic [N_BANK-1:0]              cs;
    logic [N_BANK-1:0][DATA_W-1:0]  bank_rd;
    logic [N_BANK-1:0]              wr_en;

    assign bank_sel = addr[ADDR_W-1:OFF_W];
    assign word_off = addr[OFF_W-1:0];

    bank_decoder #(.SEL_W(SEL_W)) u_dec (
        .sel (bank_sel),
        .cs  (cs)
    );

    for (genvar k = 0; k < N_BANK; k++) begin : g_bank
        mem_bank #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .cs    (cs[k]),
            .rw    (rw),
            .off   (word_off),
            .wdata (wdata),
            .rdata (bank_rd[k])
        );
        assign wr_en[k] = cs[k] && (rw_op_e'(rw) == OP_STORE);
    end

    read_steer #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_steer (
        .clk     (clk),
        .rst_n   (rst_n),
        .rw      (rw),
        .sel     (bank_sel),
        .bank_rd (bank_rd),
        .rdata   (rdata)
    );

    // R8: a store has exactly one writer, a fetch has none
    a_r8_single_writer : assert property (@(posedge clk) disable iff (!rst_n)
        (rw_op_e'(rw) == OP_STORE) |-> $onehot(wr_en));
    a_r8_fetch_no_writer : assert property (@(posedge clk) disable iff (!rst_n)
        (rw_op_e'(rw) == OP_FETCH) |-> (wr_en == '0));

endmodule

// File: tb/banked_ram_bench.sv
module banked_ram_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        rw = 1'b0;
    logic [7:0]  rdata;

    always #5 clk = ~clk;

    banked_ram u_banked_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wdata (wdata),
        .rw    (rw),
        .rdata (rdata)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t   sb_q[$];
    logic [7:0] model [4096];
    logic [7:0] last_rd = 8'h00;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         done = 1'b0;
    bit         armed = 1'b0;

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rdata=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // driver: one operation per cycle, expected port value pushed to the scoreboard
    task automatic op_store(input logic [11:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        rw = 1'b0; addr = a; wdata = d;
        model[a] = d;
        sb_q.push_back('{exp: last_rd, tag: tag});
    endtask

    task automatic op_fetch(input logic [11:0] a, input string tag);
        @(negedge clk);
        rw = 1'b1; addr = a; wdata = 8'hxx;
        last_rd = model[a];
        sb_q.push_back('{exp: last_rd, tag: tag});
    endtask

    // monitor: each edge retires the operation driven before it
    initial begin
        forever begin
            @(posedge clk);
            if (armed && sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                #1;
                check(rdata, it.exp, it.tag);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(rdata, 8'h00, "R6 during reset");
        @(negedge clk);
        rst_n = 1'b1;
        armed = 1'b1;

        // R5: stores right after reset keep the port at zero
        op_store(12'd5, 8'hA0, "R5");
        op_store(12'd1029, 8'hA1, "R5");
        op_store(12'd2053, 8'hA2, "R5");
        op_store(12'd3077, 8'hA3, "R5");
        // R1: same offset in each bank stays separate
        for (int k = 0; k < 4; k++) op_fetch(12'(k * 1024 + 5), "R1 same offset");

        // R1: window edges
        op_store(12'd1023, 8'h11, "R5");
        op_store(12'd1024, 8'h22, "R5");
        op_store(12'd2047, 8'h33, "R5");
        op_store(12'd2048, 8'h44, "R5");
        op_store(12'd3071, 8'h55, "R5");
        op_store(12'd3072, 8'h66, "R5");
        op_store(12'd4095, 8'h77, "R5");
        op_store(12'd0,    8'h88, "R5");
        op_fetch(12'd1023, "R1 edge");
        op_fetch(12'd1024, "R1 edge");
        op_fetch(12'd2047, "R1 edge");
        op_fetch(12'd2048, "R1 edge");
        op_fetch(12'd3071, "R1 edge");
        op_fetch(12'd3072, "R1 edge");
        op_fetch(12'd4095, "R1 edge");
        op_fetch(12'd0,    "R1 edge");

        // R4: back-to-back fetches hopping banks
        op_fetch(12'd3077, "R4");
        op_fetch(12'd5,    "R4");
        op_fetch(12'd2053, "R4");
        op_fetch(12'd1029, "R4");
        op_fetch(12'd4095, "R4");
        op_fetch(12'd0,    "R4");

        // R5: stores between fetches leave last word visible
        op_fetch(12'd2048, "R3");
        op_store(12'd2048, 8'h5A, "R5 hold");
        op_store(12'd7, 8'hC3, "R5 hold");

        // R7: fetch right after store at the same address
        op_fetch(12'd2048, "R7");
        op_store(12'd3500, 8'h9E, "R5");
        op_fetch(12'd3500, "R7");

        // R2: overwrite one word, neighbours and aliases unchanged
        op_store(12'd5, 8'hF0, "R5");
        op_fetch(12'd5,    "R2 target");
        op_fetch(12'd1029, "R2 alias");
        op_fetch(12'd2053, "R2 alias");
        op_fetch(12'd3077, "R2 alias");
        op_fetch(12'd7,    "R2 neighbour");

        // R2/R3: spread pattern across all banks
        for (int i = 0; i < 64; i++) op_store(12'(i * 64 + (i % 7)), 8'(i * 37 + 3), "R5");
        for (int i = 63; i >= 0; i--) op_fetch(12'(i * 64 + (i % 7)), "R2 pattern");

        // R3: held value persists over an idle-store gap
        op_fetch(12'd4095, "R3");
        op_store(12'd100, 8'h01, "R3 stays");

        @(negedge clk);
        rw = 1'b0;
        addr = 12'd100;
        wdata = 8'h01;
        repeat (3) @(posedge clk);
        #2;
        armed = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule